// File: doc/BRIEF.md
# Self-Correcting Synchronous Decade Counter

This block is a single synchronous decimal digit counter held in four flip-flops. While its count enable is high it steps 0, 1, ..., 9 and then back to 0. Its next state comes from fixed exclusive-OR equations rather than from a decode of the legal codes. Because of this, each of the six codes above 9 also has a defined successor, and a digit that has been upset into one of them reaches the decimal sequence again within two enabled clocks. No reset is needed for that recovery.

A terminal-count output rises only while the digit shows 9 and the enable is high. Feeding it into the enable of the next digit builds a multi-digit counter with no further logic. A combinational flag reports when the stored code is not a decimal digit. A test load port writes any 4-bit code, so that the behaviour of the unused codes can be exercised.

Top module: `scbcd_counter`

## Requirements
- R1: A high `rst` at a rising clock edge sets `digit` to 0 (code 0000). It overrides both `load_en` and `cnt_en`.
- R2: With `cnt_en` high and `rst` and `load_en` low, each rising edge moves `digit` from d to d+1 for d in 0..8, and from 9 to 0.
- R3: `term_cnt` is 1 exactly when `digit` equals 9 (code 1001) and `cnt_en` is 1. It is 0 otherwise, including at 9 with the enable low.
- R4: With `cnt_en`, `rst` and `load_en` all low, `digit` keeps its value across a clock edge. This holds for legal and unused codes alike.
- R5: On an enabled edge the unused codes move as follows: 11 goes to 6, 13 to 4, 15 to 2, 10 to 11, 12 to 13 and 14 to 15. `digit` bit 3 has weight 8 and bit 0 has weight 1.
- R6: From any unused code, at most two consecutive enabled edges bring `digit` back into 0..9. The odd unused codes need one edge and the even ones need two.
- R7: `invalid` is 1 whenever `digit` holds a code from 10 to 15, that is, bit 3 set together with bit 2 or bit 1. It is 0 for 0..9 and follows `digit` with no added clock delay.
- R8: A high `load_en` with `rst` low writes `load_val` into `digit` at the next edge, whatever `cnt_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| load_en | input | 1 | Test load strobe |
| load_val | input | 4 | Code written by the test load |
| digit | output | 4 | Current code, bit 3 has weight 8 |
| term_cnt | output | 1 | High at 9 while enabled, for cascading |
| invalid | output | 1 | Stored code is 10..15 |

## Verification
The bench loads each of the sixteen codes and checks its single successor. A design that decoded only the legal codes, or that forced illegal codes straight to zero, would show the wrong successors for 10 through 15. It also walks every unused code to the legal range and counts the edges taken, which catches a design that loops among the unused codes. Finally it checks that the terminal count drops when the enable is low at 9, and that reset beats both the load and the enable, since a wrong priority would either stall a cascade or leave a stale digit.

// File: rtl/scbcd_pkg.sv
package scbcd_pkg;
  localparam int DIGIT_W = 4;
  localparam int RADIX   = 10;
  localparam logic [DIGIT_W-1:0] TOP_DIGIT = DIGIT_W'(RADIX - 1);

  typedef logic [DIGIT_W-1:0] digit_t;

  // Exclusive-OR next-state equations; bit index 0 has weight 1, index 3 weight 8.
  function automatic digit_t step_code(digit_t q);
    digit_t n;
    n[0] = ~q[0];
    n[1] = q[1] ^ (q[0] & ~q[3]);
    n[2] = q[2] ^ (q[0] & q[1]);
    n[3] = q[3] ^ ((q[0] & q[3]) | (q[0] & q[1] & q[2]));
    return n;
  endfunction

  // Codes 10..15 are the ones with weight 8 plus weight 4 or weight 2.
  function automatic logic code_unused(digit_t q);
    return q[3] & (q[2] | q[1]);
  endfunction
endpackage

// File: rtl/scbcd_next.sv
module scbcd_next
  import scbcd_pkg::*;
(
  input  logic [DIGIT_W-1:0] cur,
  output logic [DIGIT_W-1:0] nxt
);
  always_comb nxt = step_code(cur);

  // r5_/r6_: any unused odd code lands in the legal range after one step
  always_comb begin
    if (code_unused(cur) && cur[0])
      a_odd_exit_r6: assert (!code_unused(nxt));
  end
endmodule

// File: rtl/scbcd_state.sv
module scbcd_state
  import scbcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [DIGIT_W-1:0] load_val,
  input  logic               adv,
  input  logic [DIGIT_W-1:0] nxt,
  output logic [DIGIT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= load_val;
    else if (adv)     q <= nxt;
  end

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> (q == '0));
  p_load_takes_r8: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q == $past(load_val)));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !adv) |=> $stable(q));
endmodule

// File: rtl/scbcd_flags.sv
module scbcd_flags
  import scbcd_pkg::*;
(
  input  logic [DIGIT_W-1:0] q,
  input  logic               cnt_en,
  output logic               term_cnt,
  output logic               invalid
);
  logic at_top;
  always_comb begin
    at_top   = (q == TOP_DIGIT);
    term_cnt = at_top & cnt_en;
    invalid  = code_unused(q);
  end

  always_comb begin
    a_tc_legal_r3: assert (!(term_cnt && invalid));
    a_flag_range_r7: assert (invalid == (q > TOP_DIGIT));
  end
endmodule

// File: rtl/scbcd_counter.sv
module scbcd_counter
  import scbcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  input  logic       load_en,
  input  logic [3:0] load_val,
  output logic [3:0] digit,
  output logic       term_cnt,
  output logic       invalid
);
  digit_t q_cur, q_nxt;
  logic   advance;

  assign advance = cnt_en & ~load_en;

  scbcd_next u_next (.cur(q_cur), .nxt(q_nxt));

  scbcd_state u_state (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .adv(advance), .nxt(q_nxt), .q(q_cur));

  scbcd_flags u_flags (
    .q(q_cur), .cnt_en(cnt_en), .term_cnt(term_cnt), .invalid(invalid));

  assign digit = q_cur;

  // Named events for the properties below.
  logic step_evt, wrap_evt, odd_bad_evt, even_bad_evt;
  assign step_evt     = advance & ~rst;
  assign wrap_evt     = step_evt & term_cnt;
  assign odd_bad_evt  = step_evt & invalid & q_cur[0];
  assign even_bad_evt = step_evt & invalid & ~q_cur[0];

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (digit == 4'd0));
  p_legal_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (step_evt && !invalid && !term_cnt) |=> (digit == $past(digit) + 4'd1));
  p_odd_recover_r6: assert property (@(posedge clk) disable iff (rst)
    odd_bad_evt |=> !invalid);
  p_even_to_odd_r5: assert property (@(posedge clk) disable iff (rst)
    even_bad_evt |=> (invalid && digit[0]));
endmodule

// File: tb/test_scbcd_counter.sv
module test_scbcd_counter;
  localparam int PERIOD = 10;

  logic       clk = 0;
  logic       rst, cnt_en, load_en;
  logic [3:0] load_val;
  logic [3:0] digit;
  logic       term_cnt, invalid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  scbcd_counter i_scbcd_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_en(load_en),
    .load_val(load_val), .digit(digit), .term_cnt(term_cnt), .invalid(invalid));

  // Successor of each code on one enabled edge (R2 for 0..9, R5 for 10..15).
  localparam logic [3:0] SUCC [16] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
                                      4'd9, 4'd0, 4'd11, 4'd6, 4'd13, 4'd4, 4'd15, 4'd2};

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_code(logic [3:0] v);
    load_en = 1; load_val = v; cnt_en = 0;
    tick();
    load_en = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; cnt_en = 0; load_en = 0; load_val = 0;
    tick(); tick();
    check("R1 reset digit", digit, 4'd0);
    check("R7 invalid at reset", {3'b0, invalid}, 4'd0);
    rst = 0;

    // Table walk: every code and its single successor (R5, R8, R7).
    for (int c = 0; c < 16; c++) begin
      load_code(4'(c));
      check("R8 load value", digit, 4'(c));
      check("R7 invalid flag", {3'b0, invalid}, {3'b0, (c > 9)});
      cnt_en = 1;
      tick();
      cnt_en = 0;
      check((c > 9) ? "R5 unused successor" : "R2 legal successor", digit, SUCC[c]);
    end

    // Full count from reset with terminal count (R2, R3).
    rst = 1; tick(); rst = 0;
    cnt_en = 1;
    for (int k = 0; k < 25; k++) begin
      check("R2 count sequence", digit, 4'(k % 10));
      check("R3 term_cnt", {3'b0, term_cnt}, {3'b0, (k % 10 == 9)});
      tick();
    end

    // Terminal count gated by the enable, and hold (R3, R4).
    load_code(4'd9);
    check("R3 term_cnt low when disabled", {3'b0, term_cnt}, 4'd0);
    tick(); tick();
    check("R4 hold at 9", digit, 4'd9);
    load_code(4'd12);
    tick(); tick();
    check("R4 hold on unused code", digit, 4'd12);
    check("R7 invalid while held", {3'b0, invalid}, 4'd1);

    // Recovery bound (R6).
    for (int c = 10; c < 16; c++) begin
      int steps;
      load_code(4'(c));
      cnt_en = 1;
      steps = 0;
      while (invalid && steps < 5) begin
        tick();
        steps++;
      end
      cnt_en = 0;
      check("R6 recovery edges", 4'(steps), (c % 2 == 1) ? 4'd1 : 4'd2);
    end

    // Priorities: reset over load and enable (R1), load over enable (R8).
    load_code(4'd5);
    rst = 1; load_en = 1; load_val = 4'd7; cnt_en = 1;
    tick();
    rst = 0; load_en = 0; cnt_en = 0;
    check("R1 reset beats load and enable", digit, 4'd0);
    load_en = 1; load_val = 4'd3; cnt_en = 1;
    tick();
    load_en = 0; cnt_en = 0;
    check("R8 load beats enable", digit, 4'd3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule